// File: doc/BRIEF.md
# Lockable Flash Timing Tick Divider

This block turns the bus clock into a slow timing tick of about 1 MHz. Flash program and erase sequencing uses the tick to time its events. Software sets the rate through one control register that is always readable. The register holds a 6-bit divide value, a lock flag and a status flag. The status flag shows whether the register has been written since reset.

In normal mode the lock flag can only be set. Once set, it freezes the divide value until the next reset. In special mode the lock flag and the divide value can both be rewritten freely.

Writes are refused while the flash command logic reports that a command is busy. The tick stays low until the register has been written at least once, so an unconfigured divider never produces a tick.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `tick` is low.
- R2: `rd_data` always shows {loaded, lock, div} at bit positions 7, 6 and 5:0. The value of `wr_data[7]` never changes bit 7 in either mode: a write with bit 7 at 0 does not clear it.
- R3: An accepted write is `wr_en`=1 while `cmd_busy`=0. Bit 7 reads 0 until the first accepted write after reset. It reads 1 from the cycle after that write onward.
- R4: In normal mode (`special_mode`=0), an accepted write with bit 6 at 1 sets the lock flag. A write with bit 6 at 0 does not clear it. Only reset clears it.
- R5: In normal mode, while the lock flag reads 1, accepted writes leave bits 5:0 unchanged. A write that sets the lock from 0 still loads bits 5:0.
- R6: In special mode (`special_mode`=1), every accepted write copies `wr_data[6:0]` into bits 6:0, whatever the lock state. This can clear the lock flag.
- R7: A `wr_en` pulse while `cmd_busy`=1 changes no register bit.
- R8: While bit 7 is 1 and the divide value D is steady, `tick` is high for one cycle in every D+1 cycles. With D=0, `tick` is high on every cycle.
- R9: An accepted write that changes D restarts the count. The cycle right after the write's clock edge is the first cycle of the new count, and `tick` is first high D cycles later.
- R10: `tick` stays low while bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | 1 selects special mode, 0 selects normal mode |
| cmd_busy | input | 1 | A flash command is running; writes are refused |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents {loaded, lock, div} |
| tick | output | 1 | One-cycle timing pulse at the divided rate |

## Verification
The assertions assume that `special_mode`, `cmd_busy`, `wr_en` and `wr_data` change only between clock edges. They also assume that the mode applying to a write is the one sampled at that write's edge. The bench therefore drives every input at the falling edge.

The random stimulus flips the mode only rarely, so that long normal-mode stretches with the lock set actually occur. It skews the divide values toward small numbers, so that many full tick periods fit between writes. It refuses about one write in five through the busy input.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  // Default width of the divide field; the register adds two flag bits above it.
  localparam int DIV_W_DEF = 6;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_SPECIAL = 1'b1
  } ftd_mode_e;
endpackage

// File: rtl/ftd_write_gate.sv
module ftd_write_gate (
  input  logic wr_en,
  input  logic cmd_busy,
  output logic wr_accept
);
  // A write is refused while a flash command is running.
  assign wr_accept = wr_en & ~cmd_busy;
endmodule

// File: rtl/ftd_cfg_reg.sv
module ftd_cfg_reg #(
  parameter int DIV_W = ftd_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_mode,
  input  logic             wr_accept,
  input  logic [DIV_W+1:0] wr_data,
  output logic             loaded,
  output logic             lock,
  output logic [DIV_W-1:0] div,
  output logic             div_reload
);
  localparam int LOCK_BIT = DIV_W;

  ftd_pkg::ftd_mode_e mode;
  assign mode = ftd_pkg::ftd_mode_e'(special_mode);

  // Next lock value for an accepted write.
  function automatic logic lock_next(input ftd_pkg::ftd_mode_e m,
                                     input logic cur, input logic wbit);
    if (m == ftd_pkg::MODE_SPECIAL) return wbit;
    return cur | wbit;
  endfunction

  // Next divide value for an accepted write: frozen only by a lock that
  // was already set in normal mode.
  function automatic logic [DIV_W-1:0] div_next(input ftd_pkg::ftd_mode_e m,
                                                input logic cur_lock,
                                                input logic [DIV_W-1:0] cur,
                                                input logic [DIV_W-1:0] wval);
    if (m == ftd_pkg::MODE_NORMAL && cur_lock) return cur;
    return wval;
  endfunction

  logic [DIV_W-1:0] div_d;
  logic             lock_d;

  always_comb begin
    div_d  = div;
    lock_d = lock;
    if (wr_accept) begin
      div_d  = div_next(mode, lock, div, wr_data[DIV_W-1:0]);
      lock_d = lock_next(mode, lock, wr_data[LOCK_BIT]);
    end
  end

  // The counter restarts whenever the divide field takes a new value.
  assign div_reload = (div_d != div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      lock   <= 1'b0;
      div    <= '0;
    end else begin
      if (wr_accept) loaded <= 1'b1;
      lock <= lock_d;
      div  <= div_d;
    end
  end
endmodule

// File: rtl/ftd_tick_counter.sv
module ftd_tick_counter #(
  parameter int DIV_W = ftd_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] cnt,
  output logic             tick
);
  // Counts 0..div and wraps; a shrunken limit wraps at once.
  function automatic logic [DIV_W-1:0] count_next(input logic [DIV_W-1:0] c,
                                                  input logic [DIV_W-1:0] lim);
    if (c >= lim) return '0;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= '0;
    else             cnt <= count_next(cnt, div);
  end

  assign tick = enable && (cnt == div);
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
  parameter int DIV_W = ftd_pkg::DIV_W_DEF,
  localparam int REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_mode,
  input  logic             cmd_busy,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);
  // Named internal events, observed by the bound checker.
  logic             wr_accept;
  logic             div_reload;
  logic             cfg_loaded;
  logic             cfg_lock;
  logic [DIV_W-1:0] cfg_div;
  logic [DIV_W-1:0] cnt_q;

  ftd_write_gate gate_i (
    .wr_en    (wr_en),
    .cmd_busy (cmd_busy),
    .wr_accept(wr_accept)
  );

  ftd_cfg_reg #(.DIV_W(DIV_W)) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .special_mode(special_mode),
    .wr_accept   (wr_accept),
    .wr_data     (wr_data),
    .loaded      (cfg_loaded),
    .lock        (cfg_lock),
    .div         (cfg_div),
    .div_reload  (div_reload)
  );

  ftd_tick_counter #(.DIV_W(DIV_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .reload(div_reload),
    .enable(cfg_loaded),
    .div   (cfg_div),
    .cnt   (cnt_q),
    .tick  (tick)
  );

  assign rd_data = {cfg_loaded, cfg_lock, cfg_div};
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
  parameter int DIV_W = ftd_pkg::DIV_W_DEF,
  localparam int REG_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             special_mode,
  input logic             wr_accept,
  input logic [REG_W-1:0] rd_data,
  input logic             tick,
  input logic             div_reload,
  input logic [DIV_W-1:0] cnt
);
  localparam int LD = DIV_W + 1;
  localparam int LK = DIV_W;

  // R3: the loaded flag never drops once set
  a_r3_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LD] |=> rd_data[LD]);

  // R7: without an accepted write nothing in the register moves
  a_r7_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(rd_data));

  // R4: in normal mode a set lock stays set
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && rd_data[LK]) |=> rd_data[LK]);

  // R5: in normal mode a set lock freezes the divide field
  a_r5_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && rd_data[LK]) |=> $stable(rd_data[DIV_W-1:0]));

  // R10: no tick before the first write
  a_r10_quiet_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[LD] |-> !tick);

  // R8: a zero divide ticks every cycle once loaded
  a_r8_zero_div_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[LD] && rd_data[DIV_W-1:0] == '0) |-> tick);

  // R9: a change of divide value restarts the count from zero
  a_r9_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    div_reload |=> (cnt == '0));
endmodule

bind flash_tick_divider ftd_checker #(.DIV_W(DIV_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .special_mode(special_mode),
  .wr_accept   (wr_accept),
  .rd_data     (rd_data),
  .tick        (tick),
  .div_reload  (div_reload),
  .cnt         (cnt_q)
);

// File: tb/flash_tick_divider_tb_top.sv
module flash_tick_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       cmd_busy = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  bit       m_loaded, m_lock;
  bit [5:0] m_div;
  int       m_since;

  always #2 clk = ~clk;

  flash_tick_divider dut_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .cmd_busy(cmd_busy),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_tick();
    if (!m_loaded) return 1'b0;
    return (m_since % (int'(m_div) + 1)) == int'(m_div);
  endfunction

  task automatic check_all();
    check("R3 loaded bit", int'(rd_data[7]), int'(m_loaded));
    check("R4 lock bit", int'(rd_data[6]), int'(m_lock));
    check("R5 div field", int'(rd_data[5:0]), int'(m_div));
    check("R8 tick", int'(tick), int'(exp_tick()));
  endtask

  // Drive one cycle at the falling edge, predict the register after the
  // next rising edge, then compare at the following falling edge.
  task automatic drive(input bit we, input bit [7:0] d, input bit busy, input bit mode);
    bit       nl, nk;
    bit [5:0] nd;
    wr_en = we; wr_data = d; cmd_busy = busy; special_mode = mode;
    nl = m_loaded; nk = m_lock; nd = m_div;
    if (we && !busy) begin
      nl = 1'b1;
      if (mode) begin
        nk = d[6]; nd = d[5:0];
      end else begin
        if (!m_lock) nd = d[5:0];
        nk = m_lock | d[6];
      end
    end
    @(negedge clk);
    m_since = (nd != m_div) ? 0 : m_since + 1;
    m_loaded = nl; m_lock = nk; m_div = nd;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    bit mode_r;
    s = $urandom(32'd20517);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_loaded = 0; m_lock = 0; m_div = 0; m_since = 0;
    check("R1 reset rd_data", int'(rd_data), 0);
    check("R1 reset tick", int'(tick), 0);

    // R10: no tick while unwritten, also with a busy-refused write
    for (int i = 0; i < 5; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);
    check("R10 tick unloaded", int'(tick), 0);
    drive(1'b1, 8'h03, 1'b1, 1'b0);
    check("R7 busy write refused", int'(rd_data), 8'h00);
    check("R10 tick still low", int'(tick), 0);

    // first real write: bit 7 of data is ignored, loaded flag appears
    drive(1'b1, 8'h03, 1'b0, 1'b0);
    check("R3 loaded after write", int'(rd_data), 8'h83);
    check("R9 tick low at count start", int'(tick), 0);
    for (int i = 0; i < 2; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);
    check("R9 tick low before D", int'(tick), 0);
    drive(1'b0, 8'h00, 1'b0, 1'b0);
    check("R9 first tick after D cycles", int'(tick), 1);
    for (int i = 0; i < 12; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);

    // R2: write with bit 7 clear does not clear it
    drive(1'b1, 8'h02, 1'b0, 1'b0);
    check("R2 bit7 not writable", int'(rd_data), 8'h82);

    // R8: divide 0 ticks every cycle
    drive(1'b1, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check("R8 zero div tick", int'(tick), 1);
      drive(1'b0, 8'h00, 1'b0, 1'b0);
    end

    // R4/R5: lock in normal mode
    drive(1'b1, 8'h45, 1'b0, 1'b0);
    check("R4 lock set with div", int'(rd_data), 8'hC5);
    drive(1'b1, 8'h0A, 1'b0, 1'b0);
    check("R5 locked div unchanged", int'(rd_data), 8'hC5);
    check("R4 lock not cleared", int'(rd_data[6]), 1);
    for (int i = 0; i < 14; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);

    // R7 in special mode, then R6 rewrite clears lock
    drive(1'b1, 8'h01, 1'b1, 1'b1);
    check("R7 busy special refused", int'(rd_data), 8'hC5);
    drive(1'b1, 8'h02, 1'b0, 1'b1);
    check("R6 special rewrite", int'(rd_data), 8'h82);
    drive(1'b1, 8'h47, 1'b0, 1'b1);
    drive(1'b1, 8'h04, 1'b0, 1'b1);
    check("R6 special clears lock", int'(rd_data), 8'h84);

    // constrained random phase
    mode_r = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      bit [7:0] d;
      bit we, busy;
      if ($urandom % 60 == 0) mode_r = ~mode_r;
      we   = ($urandom % 10) < 3;
      busy = ($urandom % 5) == 0;
      d    = 8'($urandom);
      if ($urandom % 4 != 0) d[5:0] = 6'($urandom % 6);
      drive(we, d, busy, mode_r);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule